// File: doc/BRIEF.md
# Vertical-Crosswise 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and presents the 8-bit product with no clock and no storage. The output follows the inputs through gates alone, so a consumer can sample it in the same cycle that the operands change.

The product is assembled hierarchically rather than from a flat grid of partial products. Each operand is split into a low pair (bits 1..0) and a high pair (bits 3..2). Four small 2x2 cells form the four pairwise products low·low, high·low, low·high and high·high. Each cell is built only from four 2-input AND gates and two half adders. The bottom bit of a cell is the AND of the two low bits. Its next bit is the half-adder sum of the two crosswise AND terms. A second half adder folds that carry into the AND of the two high bits and gives the top two bits. Ripple adders built from half-adder pairs then add the two cross products, plus the upper half of the low·low result, at weight 4. The high·high product goes in at weight 16.

Top module: `vcMul4x4`

## Requirements
- R1: When both operands are below 4, product bit 0 equals opA[0] AND opB[0].
- R2: When both operands are below 4, product bit 1 equals (opA[1]·opB[0]) XOR (opA[0]·opB[1]).
- R3: When both operands are below 4, product bits 3..2 hold the carry chain of the leaf cell, so that product equals opA·opB (for example 3·3 gives 4'b1001), and bits 7..4 are zero.
- R4: Product bits 1..0 depend only on opA[1:0] and opB[1:0] and equal (opA[1:0]·opB[1:0]) mod 4, whatever the high bits are.
- R5: If either operand is zero, the product is zero.
- R6: If either operand is one, the product equals the other operand.
- R7: For all 256 operand pairs the 8-bit product equals the exact unsigned product opA·opB, and it is valid once the combinational logic settles, with no clock involved.
- R8: The largest case, 15·15, gives 8'hE1 with no carry lost from the top adder.
- R9: Swapping the operands gives the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | Unsigned multiplicand |
| opB | input | 4 | Unsigned multiplier |
| product | output | 8 | Unsigned product opA·opB |

## Verification
The bench walks every operand pair and holds a behavioural product table, so a misrouted cell, for example one fed high·low where low·high belongs, shows up as a wrong product for asymmetric operands even when the symmetric cases still pass. Operands below 4 exercise a single leaf cell alone. A swapped crosswise term or a wrong second half adder there corrupts bits 1 to 3 for cases such as 2·1 and 3·3. Operand 15 against 15 drives every carry through the combining adders, and a dropped carry out of the middle sum loses weight 16 there. Products with a zero or unit operand, and the low two bits with the high halves changing, catch cross terms that leak into the wrong weight.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int OPER_W = 4;
  localparam int HALF_W = OPER_W / 2;
  localparam int LEAF_W = 2 * HALF_W;
  localparam int PROD_W = 2 * OPER_W;
  localparam int CELL_N = 4;
  localparam int MID_W  = LEAF_W + 1;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [LEAF_W-1:0] leaf_t;

  // Four cell results handed from the cell array to the combining adders.
  typedef struct packed {
    leaf_t hh;
    leaf_t lh;
    leaf_t hl;
    leaf_t ll;
  } leafSet_t;
endpackage

// File: rtl/vcHalfAdder.sv
module vcHalfAdder (
  input  logic x,
  input  logic y,
  output logic sum,
  output logic carry
);
  assign sum   = x ^ y;
  assign carry = x & y;
endmodule

// File: rtl/vcRippleAdd.sv
module vcRippleAdd #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : gBit
    logic s1, c1, c2;
    vcHalfAdder firstHa (.x(x[i]), .y(y[i]),     .sum(s1),     .carry(c1));
    vcHalfAdder secondHa(.x(s1),   .y(chain[i]), .sum(sum[i]), .carry(c2));
    assign chain[i+1] = c1 | c2;
  end

  assign cout = chain[W];
endmodule

// File: rtl/vcLeafCell.sv
module vcLeafCell (
  input  logic [1:0] aIn,
  input  logic [1:0] bIn,
  output logic [3:0] prodOut
);
  logic ppLow, ppAHi, ppBHi, ppHigh, crossCarry;

  // Four AND gates: one vertical at each end, two crosswise.
  assign ppLow  = aIn[0] & bIn[0];
  assign ppAHi  = aIn[1] & bIn[0];
  assign ppBHi  = aIn[0] & bIn[1];
  assign ppHigh = aIn[1] & bIn[1];

  assign prodOut[0] = ppLow;

  vcHalfAdder crossHa(.x(ppAHi),      .y(ppBHi),  .sum(prodOut[1]), .carry(crossCarry));
  vcHalfAdder topHa  (.x(crossCarry), .y(ppHigh), .sum(prodOut[2]), .carry(prodOut[3]));

  always_comb begin
    AST_LEAF_EXACT: assert (prodOut == ({2'b00, aIn} * {2'b00, bIn}))
      else $error("leaf cell product wrong"); // R3
  end
endmodule

// File: rtl/vcCombiner.sv
module vcCombiner
  import vcm_pkg::*;
(
  input  leafSet_t           cells,
  output logic [PROD_W-1:0]  product
);
  logic [LEAF_W:0]   crossSum;
  logic [MID_W-1:0]  midSum;
  logic              midCarry;
  logic [LEAF_W-1:0] upperSum;
  logic              upperCarry;

  // Weight 4: both cross products.
  vcRippleAdd #(.W(LEAF_W)) crossAdd (
    .x(cells.hl), .y(cells.lh), .cin(1'b0),
    .sum(crossSum[LEAF_W-1:0]), .cout(crossSum[LEAF_W])
  );

  // Weight 4: fold in the upper half of the low·low product.
  vcRippleAdd #(.W(MID_W)) midAdd (
    .x(crossSum),
    .y({{(MID_W-HALF_W){1'b0}}, cells.ll[LEAF_W-1:HALF_W]}),
    .cin(1'b0), .sum(midSum), .cout(midCarry)
  );

  // Weight 16: high·high plus what rose out of the middle.
  vcRippleAdd #(.W(LEAF_W)) upperAdd (
    .x(cells.hh),
    .y({{(LEAF_W-(MID_W-HALF_W)){1'b0}}, midSum[MID_W-1:HALF_W]}),
    .cin(1'b0), .sum(upperSum), .cout(upperCarry)
  );

  assign product = {upperSum, midSum[HALF_W-1:0], cells.ll[HALF_W-1:0]};

  always_comb begin
    AST_MID_NO_OVERFLOW: assert (!midCarry)
      else $error("middle sum overflowed"); // R7
    AST_UPPER_NO_OVERFLOW: assert (!upperCarry)
      else $error("upper sum overflowed"); // R8
  end
endmodule

// File: rtl/vcMul4x4.sv
module vcMul4x4
  import vcm_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  output logic [7:0] product
);
  leaf_t    cellProd [CELL_N];
  leafSet_t cellSet;

  // Cell index bit 0 picks the high pair of opA, bit 1 the high pair of opB.
  for (genvar i = 0; i < CELL_N; i++) begin : gCell
    half_t aSel, bSel;
    assign aSel = i[0] ? opA[OPER_W-1:HALF_W] : opA[HALF_W-1:0];
    assign bSel = i[1] ? opB[OPER_W-1:HALF_W] : opB[HALF_W-1:0];
    vcLeafCell leaf (.aIn(aSel), .bIn(bSel), .prodOut(cellProd[i]));
  end

  assign cellSet.ll = cellProd[0];
  assign cellSet.hl = cellProd[1];
  assign cellSet.lh = cellProd[2];
  assign cellSet.hh = cellProd[3];

  vcCombiner combine (.cells(cellSet), .product(product));

  always_comb begin
    AST_FULL_PRODUCT: assert (product == ({4'b0, opA} * {4'b0, opB}))
      else $error("product mismatch"); // R7
    AST_ZERO_OPERAND: assert (!(opA == 4'd0 || opB == 4'd0) || product == 8'd0)
      else $error("zero operand gave nonzero"); // R5
    AST_UNIT_OPERAND: assert (!(opB == 4'd1) || product == {4'b0, opA})
      else $error("unit operand changed value"); // R6
    AST_LOW_BITS: assert (product[1:0] == 2'(opA[1:0] * opB[1:0]))
      else $error("low bits wrong"); // R4
  end
endmodule

// File: tb/vcMul4x4_test.sv
`timescale 1ns/1ps
module vcMul4x4_test;
  logic       clk = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [7:0] product;
  int checks = 0;
  int errors = 0;
  int seen [256];
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcMul4x4 uut (.opA(opA), .opB(opB), .product(product));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    opA = 4'(a);
    opB = 4'(b);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check("R5 idle zero", int'(product), 0);

    // Single leaf cell region.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        apply(a, b);
        check("R1", int'(product[0]), (a & 1) & (b & 1));
        check("R2", int'(product[1]), (((a >> 1) & b & 1) ^ (a & (b >> 1) & 1)));
        check("R3", int'(product), a * b);
      end

    // Exhaustive sweep.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        seen[a*16+b] = int'(product);
        check("R7", int'(product), a * b);
        check("R4", int'(product[1:0]), ((a % 4) * (b % 4)) % 4);
        if (a == 0 || b == 0) check("R5", int'(product), 0);
        if (b == 1) check("R6", int'(product), a);
        if (a == 1) check("R6", int'(product), b);
      end

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        check("R9", seen[a*16+b], seen[b*16+a]);

    // Low bits stay fixed while only the high halves move.
    for (int h = 0; h < 4; h++) begin
      apply(h * 4 + 3, (3 - h) * 4 + 2);
      check("R4 high-half change", int'(product[1:0]), 2);
    end

    apply(15, 15);
    check("R8", int'(product), 8'hE1);
    apply(15, 14);
    check("R8 near max", int'(product), 210);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule